// File: doc/BRIEF.md
# Multiplexed Parallel Sample Readout Port

This block holds the most recent I/Q results of two receive channels (A and B) and presents them to a host on a shared 16-bit parallel bus. Each channel's I and Q result is a 32-bit word, so there are four words. Each word splits into an upper and a lower 16-bit segment. A 3-bit select input picks one of the eight segments. An active-low enable decides whether the block drives the bus, so several devices can share the same wires.

Results arrive on a valid/ready input. One transfer carries all four words and a format code. The block captures them together, in a single cycle, into a holding bank. As it captures, it applies the zero-fill or floating-point placement that the format calls for. On the next cycle it raises a one-cycle ready strobe. This tells the host that a new output sample period has begun. Every segment the host reads until the next capture comes from the same sample set. The conversion arithmetic (rounding, mantissa/exponent extraction) happens upstream. The input word is expected to be already left-justified, or to carry its exponent and mantissa in its low 12 bits.

The block never applies back-pressure. `in_ready` goes high on the first clock after reset is released and then stays high. A transfer takes place on every cycle where `in_valid` and `in_ready` are both high. While `in_valid` is low, the held contents do not change.

Top module: `sample_readout_port`

## Requirements
- R1: After reset, the ready strobe and `in_ready` are low. All held words are zero, so every segment reads 0x0000.
- R2: A select value s picks word s/2, where words 0..3 are A-I, A-Q, B-I, B-Q. An even s gives bits [31:16] of the word; an odd s gives bits [15:0].
- R3: While `out_en_n` is high, `bus_drive` is low and the bus is high-impedance. While it is low, `bus_drive` is high and the bus carries the selected segment.
- R4: `rdy` is high for exactly one cycle: the cycle right after a capture edge. It is low otherwise.
- R5: Without a transfer, the held words do not change, whatever the data and format inputs do.
- R6: Format code 0 (16-bit) keeps input bits [31:16] and forces bits [15:0] to zero.
- R7: Format code 1 (24-bit) keeps input bits [31:8] and forces bits [7:0] to zero.
- R8: Format code 2 (32-bit) keeps all 32 input bits.
- R9: Format code 3 (floating point) takes the exponent from input bits [11:8] and the mantissa from bits [7:0]. The upper segment reads {4'b0000, exponent, mantissa}, and the lower segment reads 0x0000.
- R10: The format code is captured with the data. A later change of `in_fmt` without a transfer does not alter the segments.
- R11: `in_ready` stays high after the first clock out of reset, so every valid input is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A sample set is offered |
| in_ready | output | 1 | Block accepts a sample set |
| in_fmt | input | 2 | Format code: 0 = 16-bit, 1 = 24-bit, 2 = 32-bit, 3 = floating point |
| in_words | input | 128 | Four 32-bit words; word k is at bits [32k+31:32k], in the order A-I, A-Q, B-I, B-Q |
| rdy | output | 1 | One-cycle strobe at the start of an output sample period |
| seg_sel | input | 3 | Segment select |
| out_en_n | input | 1 | Active-low bus drive enable |
| pbus | output | 16 | Tri-statable parallel data bus |
| bus_drive | output | 1 | High while the block drives `pbus` |

## Verification
The assertions check the following on every cycle:
- Held words do not change without a transfer.
- The low bits cleared by the 16-bit and 24-bit formats stay zero.
- The lower segment of a floating-point word reads zero.
- The bus is released whenever the enable is high.
- The strobe appears only after an accepted transfer.

Only the bench scenarios can show the rest:
- The full eight-way segment map against random data.
- The exact placement of exponent and mantissa.
- The way the held contents ignore later format and data changes until the next strobe.

// File: rtl/readout_pkg.sv
package readout_pkg;
  localparam int WORD_W  = 32;
  localparam int SEG_W   = 16;
  localparam int EXP_W   = 4;
  localparam int MAN_W   = 8;
  localparam int N_WORDS = 4;

  typedef enum logic [1:0] {
    FMT_R16  = 2'd0,
    FMT_R24  = 2'd1,
    FMT_FULL = 2'd2,
    FMT_FLT  = 2'd3
  } fmt_e;
endpackage

// File: rtl/word_formatter.sv
module word_formatter
  import readout_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int SW = SEG_W,
  parameter int EW = EXP_W,
  parameter int MW = MAN_W
) (
  input  logic [W-1:0] raw,
  input  fmt_e         fmt,
  output logic [W-1:0] shaped
);
  localparam int KEEP16 = 16;
  localparam int KEEP24 = 24;
  localparam int FLT_W  = EW + MW;

  function automatic logic [W-1:0] top_mask(input int keep);
    logic [W-1:0] m;
    m = '0;
    for (int b = 0; b < W; b++) m[b] = (b >= W - keep);
    return m;
  endfunction

  logic [SW-1:0] flt_seg;

  always_comb begin
    flt_seg = '0;
    flt_seg[FLT_W-1:0] = raw[FLT_W-1:0];
    unique case (fmt)
      FMT_R16:  shaped = raw & top_mask(KEEP16);
      FMT_R24:  shaped = raw & top_mask(KEEP24);
      FMT_FULL: shaped = raw;
      default:  shaped = {flt_seg, {(W-SW){1'b0}}};
    endcase
  end
endmodule

// File: rtl/sample_bank.sv
module sample_bank
  import readout_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int NW = N_WORDS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  fmt_e          fmt_in,
  input  logic [NW*W-1:0] words_in,
  output logic [NW*W-1:0] words_q,
  output fmt_e          fmt_q,
  output logic          strobe
);
  logic [NW*W-1:0] shaped;

  for (genvar k = 0; k < NW; k++) begin : g_fmt
    word_formatter #(.W(W)) u_fmt (
      .raw   (words_in[k*W +: W]),
      .fmt   (fmt_in),
      .shaped(shaped[k*W +: W])
    );

    assert_r24_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt_q == FMT_R24) |-> (words_q[k*W +: 8] == 8'h00));
    assert_r16_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt_q == FMT_R16) |-> (words_q[k*W +: 16] == 16'h0000));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      words_q <= '0;
      fmt_q   <= FMT_FULL;
      strobe  <= 1'b0;
    end else begin
      strobe <= cap;
      if (cap) begin
        words_q <= shaped;
        fmt_q   <= fmt_in;
      end
    end
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> ($stable(words_q) && $stable(fmt_q)));
endmodule

// File: rtl/segment_mux.sv
module segment_mux
  import readout_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int SW = SEG_W,
  parameter int NW = N_WORDS,
  localparam int SEGS  = NW * (W / SW),
  localparam int SEL_W = $clog2(SEGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NW*W-1:0] words,
  input  fmt_e            fmt_q,
  input  logic [SEL_W-1:0] sel,
  output logic [SW-1:0]   seg
);
  localparam int PER_W = W / SW;

  logic [SW-1:0] seg_arr [SEGS];

  for (genvar s = 0; s < SEGS; s++) begin : g_seg
    assign seg_arr[s] = words[(s / PER_W) * W + (PER_W - 1 - (s % PER_W)) * SW +: SW];
  end

  assign seg = seg_arr[sel];

  assert_flt_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_q == FMT_FLT && sel[0]) |-> (seg == '0));
  assert_flt_pad_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_q == FMT_FLT && !sel[0]) |-> (seg[SW-1 -: 4] == 4'h0));
endmodule

// File: rtl/sample_readout_port.sv
module sample_readout_port
  import readout_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int SW = SEG_W,
  parameter int NW = N_WORDS,
  localparam int SEL_W = $clog2(NW * (W / SW))
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_fmt,
  input  logic [NW*W-1:0]  in_words,
  output logic             rdy,
  input  logic [SEL_W-1:0] seg_sel,
  input  logic             out_en_n,
  output logic [SW-1:0]    pbus,
  output logic             bus_drive
);
  logic [NW*W-1:0] words_q;
  fmt_e            fmt_q;
  logic [SW-1:0]   seg;
  logic            cap;

  always_ff @(posedge clk) begin
    if (!rst_n) in_ready <= 1'b0;
    else        in_ready <= 1'b1;
  end

  assign cap = in_valid && in_ready;

  sample_bank #(.W(W), .NW(NW)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap     (cap),
    .fmt_in  (fmt_e'(in_fmt)),
    .words_in(in_words),
    .words_q (words_q),
    .fmt_q   (fmt_q),
    .strobe  (rdy)
  );

  segment_mux #(.W(W), .SW(SW), .NW(NW)) u_mux (
    .clk  (clk),
    .rst_n(rst_n),
    .words(words_q),
    .fmt_q(fmt_q),
    .sel  (seg_sel),
    .seg  (seg)
  );

  assign bus_drive = !out_en_n;
  assign pbus      = bus_drive ? seg : 'z;

  assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !bus_drive);
  assert_rdy_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> !rdy);
  assert_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> in_ready);
endmodule

// File: tb/sample_readout_port_tb.sv
module sample_readout_port_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 0;
  logic         rst_n = 0;
  logic         in_valid = 0;
  logic         in_ready;
  logic [1:0]   in_fmt = 0;
  logic [127:0] in_words = '0;
  logic         rdy;
  logic [2:0]   seg_sel = 0;
  logic         out_en_n = 1;
  logic [15:0]  pbus;
  logic         bus_drive;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sample_readout_port u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_fmt(in_fmt), .in_words(in_words), .rdy(rdy), .seg_sel(seg_sel),
    .out_en_n(out_en_n), .pbus(pbus), .bus_drive(bus_drive)
  );

  function automatic logic [15:0] exp_seg(input logic [31:0] w, input logic [1:0] f, input logic low);
    logic [31:0] s;
    case (f)
      2'd0: s = {w[31:16], 16'h0};
      2'd1: s = {w[31:8], 8'h0};
      2'd2: s = w;
      default: s = {4'h0, w[11:8], w[7:0], 16'h0};
    endcase
    return low ? s[15:0] : s[31:16];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_all(input string req, input logic [127:0] w, input logic [1:0] f);
    for (int s = 0; s < 8; s++) begin
      seg_sel  = 3'(s);
      out_en_n = 0;
      #1;
      check(req, {16'h0, pbus}, {16'h0, exp_seg(w[(s/2)*32 +: 32], f, s[0])});
      check("R3", {31'h0, bus_drive}, 32'd1);
    end
    out_en_n = 1;
    #1;
    check("R3", {31'h0, bus_drive}, 32'd0);
  endtask

  task automatic capture(input logic [127:0] w, input logic [1:0] f);
    @(negedge clk);
    in_words = w; in_fmt = f; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    check("R4", {31'h0, rdy}, 32'd1);
    @(negedge clk);
    check("R4", {31'h0, rdy}, 32'd0);
  endtask

  function automatic string freq(input logic [1:0] f);
    case (f)
      2'd0: return "R6";
      2'd1: return "R7";
      2'd2: return "R8";
      default: return "R9";
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [127:0] w;
    logic [1:0]   f;
    void'($urandom(32'h1234_5A5A));
    repeat (3) @(negedge clk);
    check("R1", {31'h0, rdy}, 32'd0);
    check("R1", {31'h0, in_ready}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    check("R11", {31'h0, in_ready}, 32'd1);
    read_all("R1", '0, 2'd2);

    // R2 directed: distinct pattern per word, full width
    w = {32'hB0B1_B2B3, 32'hA0A1_A2A3, 32'h9091_9293, 32'h8081_8283};
    capture(w, 2'd2);
    read_all("R2", w, 2'd2);

    // R9 directed: exponent/mantissa corners
    w = {32'hFFFF_FFFF, 32'h0000_0F00, 32'h0000_00FF, 32'h1234_5ABC};
    capture(w, 2'd3);
    read_all("R9", w, 2'd3);

    for (int n = 0; n < 40; n++) begin
      w = {$urandom, $urandom, $urandom, $urandom};
      f = 2'($urandom);
      capture(w, f);
      read_all(freq(f), w, f);
      // R5/R10: change inputs without a transfer, contents unchanged
      in_words = ~w;
      in_fmt = f + 2'd1;
      repeat (2) @(negedge clk);
      check("R4", {31'h0, rdy}, 32'd0);
      read_all("R10", w, f);
      read_all("R5", w, f);
    end

    // back-to-back captures: strobe stays high, second set wins
    @(negedge clk);
    in_words = {4{32'hDEAD_BEEF}}; in_fmt = 2'd1; in_valid = 1;
    @(negedge clk);
    check("R4", {31'h0, rdy}, 32'd1);
    in_words = {4{32'h0102_0304}}; in_fmt = 2'd0;
    @(negedge clk);
    in_valid = 0;
    check("R4", {31'h0, rdy}, 32'd1);
    check("R11", {31'h0, in_ready}, 32'd1);
    read_all("R6", {4{32'h0102_0304}}, 2'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule